// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer Mode

This block holds a bank of eight single-bit storage cells. The cells are written one at a time through a 3-bit address and a single data bit. All eight cells drive their own active-high output bits in parallel at all times. Two active-low controls choose what happens on each rising clock edge. `clr_n` is the common clear and `wr_en_n` is the write enable. Together they select one of four modes:

- Store the data bit into the addressed cell only.
- Hold every cell unchanged.
- Demultiplex the data bit onto the addressed output and drive every other output low.
- Clear the whole bank.

The block is built as a clocked register bank, so every operation takes effect on a clock edge. Address and data are only looked at on that edge, so address changes between edges cannot disturb the wrong cell. A user can build serial-to-parallel loading by stepping the address while writing. Wider banks can be built by combining several instances and gating their enables. Neither of these is part of the block itself. A separate asynchronous system reset `rst_n` clears the bank at once and is released in step with the clock.

Top module: `addr_latch`

## Requirements
- R1: While `rst_n` is low, `q` reads 8'h00 without waiting for a clock edge. After `rst_n` rises, `q` stays 8'h00 until the first mode operation that follows.
- R2: Clear mode is `clr_n`=0 and `wr_en_n`=1. It makes `q` 8'h00 after the next rising edge, whatever `addr` and `din` are.
- R3: Hold mode is `clr_n`=1 and `wr_en_n`=1. It leaves `q` unchanged across the edge, whatever `addr` and `din` are.
- R4: Write mode is `clr_n`=1 and `wr_en_n`=0. After the edge, bit `q[k]` equals `din`, where k is the unsigned value of `addr`.
- R5: In write mode, every bit of `q` other than `q[addr]` keeps its previous value.
- R6: Decode mode is `clr_n`=0 and `wr_en_n`=0. With `din`=1, `q` becomes a one-hot word with bit `addr` set and all other bits low.
- R7: Decode mode with `din`=0 makes `q` 8'h00.
- R8: Controls, `addr` and `din` are sampled only on the rising edge of `clk`, and `q` changes only as a result of that edge. Input changes between edges have no effect on `q`, and only the address present at the edge is used.
- R9: After decode mode, the pattern it left on `q` is kept until a later write or clear changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| clr_n | input | 1 | Active-low common clear control (mode select) |
| wr_en_n | input | 1 | Active-low write enable (mode select) |
| addr | input | 3 | Cell address, binary index into `q` |
| din | input | 1 | Data bit to store or route |
| q | output | 8 | One output bit per storage cell |

## Verification
The write path is first walked through every address with `din`=1, which fills the bank. One cell is then cleared, which shows that a write touches only its own cell and not its neighbours. Decode is driven with both data values and at the lowest and highest addresses, which separates the one-hot pattern from an ordinary masked write. Decode is then followed by hold and write steps, to show that the pattern persists and can later be modified. Address changes made partway through a clock period, and a mid-run pulse of the system reset, separate edge sampling from level-sensitive behaviour. A long seeded random run mixes all four modes over random contents, to catch any interaction between modes.

// File: rtl/alat_pkg.sv
`timescale 1ns/1ps
package alat_pkg;

  // Operation chosen by the two active-low controls on each edge.
  typedef enum logic [1:0] {
    MODE_HOLD   = 2'b00,
    MODE_WRITE  = 2'b01,
    MODE_DECODE = 2'b10,
    MODE_CLEAR  = 2'b11
  } alat_mode_e;

endpackage

// File: rtl/alat_rst_sync.sv
`timescale 1ns/1ps
// Asserts asynchronously, deasserts after STAGES rising edges.
module alat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/alat_mode_dec.sv
`timescale 1ns/1ps
// Maps the two active-low controls onto an operation.
module alat_mode_dec
  import alat_pkg::*;
(
  input  logic       clr_n,
  input  logic       wr_en_n,
  output alat_mode_e mode
);

  always_comb begin
    unique case ({clr_n, wr_en_n})
      2'b01:   mode = MODE_CLEAR;
      2'b00:   mode = MODE_DECODE;
      2'b10:   mode = MODE_WRITE;
      default: mode = MODE_HOLD;
    endcase
  end

endmodule

// File: rtl/alat_sel_dec.sv
`timescale 1ns/1ps
// Binary address to one-hot cell select.
module alat_sel_dec #(
  parameter int ADDR_W = 3,
  localparam int NCELLS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NCELLS-1:0] sel
);

  for (genvar gi = 0; gi < NCELLS; gi++) begin : g_sel
    assign sel[gi] = (addr == ADDR_W'(gi));
  end

endmodule

// File: rtl/alat_cell.sv
`timescale 1ns/1ps
// One storage bit with explicit next-state and load enable.
module alat_cell
  import alat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  alat_mode_e mode,
  input  logic       sel,
  input  logic       din,
  output logic       q
);

  logic q_nxt;
  logic load;

  always_comb begin
    q_nxt = q;
    load  = 1'b0;
    unique case (mode)
      MODE_CLEAR: begin
        q_nxt = 1'b0;
        load  = 1'b1;
      end
      MODE_DECODE: begin
        q_nxt = sel & din;
        load  = 1'b1;
      end
      MODE_WRITE: begin
        q_nxt = din;
        load  = sel;
      end
      default: begin
        q_nxt = q;
        load  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (load) q <= q_nxt;
  end

endmodule

// File: rtl/addr_latch.sv
`timescale 1ns/1ps
// Top: addressable bit bank with write, hold, decode and clear modes.
module addr_latch
  import alat_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int RST_STAGES = 2,
  localparam int NCELLS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic [NCELLS-1:0] q
);

  logic              rst_sync_n;
  alat_mode_e        mode;
  logic [NCELLS-1:0] sel;

  alat_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  alat_mode_dec u_mode (
    .clr_n   (clr_n),
    .wr_en_n (wr_en_n),
    .mode    (mode)
  );

  alat_sel_dec #(.ADDR_W(ADDR_W)) u_sel (
    .addr (addr),
    .sel  (sel)
  );

  for (genvar gc = 0; gc < NCELLS; gc++) begin : g_cell
    alat_cell u_cell (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .mode  (mode),
      .sel   (sel[gc]),
      .din   (din),
      .q     (q[gc])
    );
  end

  // Exactly one cell selected for any address (R4).
  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot(sel));

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr_n && wr_en_n) |=> (q == '0));

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && wr_en_n) |=> (q == $past(q)));

  p_write_bit_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && !wr_en_n) |=> (q[$past(addr)] == $past(din)));

  p_write_others_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && !wr_en_n) |=>
      (((q ^ $past(q)) & ~(NCELLS'(1) << $past(addr))) == '0));

  p_decode_pattern_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr_n && !wr_en_n) |=>
      (q == ($past(din) ? (NCELLS'(1) << $past(addr)) : '0)));

  p_decode_onehot_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr_n && !wr_en_n) |=> $onehot0(q));

endmodule

// File: tb/addr_latch_tb.sv
`timescale 1ns/1ps
module addr_latch_tb;

  localparam real CLK_PER = 20.0;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr_n;
  logic       wr_en_n;
  logic [2:0] addr;
  logic       din;
  logic [7:0] q;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] exp_q = 8'h00;

  always #(CLK_PER/2) clk = ~clk;

  addr_latch u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .wr_en_n (wr_en_n),
    .addr    (addr),
    .din     (din),
    .q       (q)
  );

  function automatic logic [7:0] model(input logic [7:0] cur, input logic c,
                                       input logic e, input logic [2:0] a,
                                       input logic d);
    logic [7:0] r;
    r = cur;
    case ({c, e})
      2'b01: r = 8'h00;
      2'b00: r = d ? (8'h01 << a) : 8'h00;
      2'b10: r[a] = d;
      default: r = cur;
    endcase
    return r;
  endfunction

  function automatic string mode_tag(input logic c, input logic e);
    case ({c, e})
      2'b01:   return "R2";
      2'b00:   return "R6";
      2'b10:   return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: q=%b expected %b", req, act, expv);
    end
  endtask

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Drive just after a falling edge, check at the following falling edge.
  task automatic step(input logic c, input logic e, input logic [2:0] a,
                      input logic d, input string req);
    clr_n = c; wr_en_n = e; addr = a; din = d;
    @(posedge clk);
    exp_q = model(exp_q, c, e, a, d);
    @(negedge clk);
    check(req, q, exp_q);
  endtask

  initial begin
    #(CLK_PER * 150000);
    n_fail++;
    $display("FAIL R8: watchdog expired, actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; wr_en_n = 1'b1; addr = 3'd0; din = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", q, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", q, 8'h00);

    // R4: fill every cell through its address
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 3'(i), 1'b1, "R4");
    check("R4", q, 8'hFF);
    // R5: clearing one cell leaves the others set
    step(1'b1, 1'b0, 3'd3, 1'b0, "R5");
    check("R5", q, 8'hF7);

    // R3: hold ignores address and data
    step(1'b1, 1'b1, 3'd3, 1'b1, "R3");
    step(1'b1, 1'b1, 3'd0, 1'b0, "R3");
    check("R3", q, 8'hF7);

    // R2: clear ignores address and data
    step(1'b0, 1'b1, 3'd5, 1'b1, "R2");
    check("R2", q, 8'h00);

    // R6 / R7: decode at ends of range and with data low
    step(1'b0, 1'b0, 3'd0, 1'b1, "R6");
    check("R6", q, 8'h01);
    step(1'b0, 1'b0, 3'd7, 1'b1, "R6");
    check("R6", q, 8'h80);
    step(1'b1, 1'b0, 3'd2, 1'b1, "R5");
    step(1'b0, 1'b0, 3'd6, 1'b0, "R7");
    check("R7", q, 8'h00);

    // R9: decode pattern persists through hold, then is modified by write
    step(1'b0, 1'b0, 3'd4, 1'b1, "R6");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 3'(i), 1'b1, "R9");
    check("R9", q, 8'h10);
    step(1'b1, 1'b0, 3'd0, 1'b1, "R9");
    check("R9", q, 8'h11);

    // R8: mid-period address change; only the edge value counts
    clr_n = 1'b1; wr_en_n = 1'b0; addr = 3'd1; din = 1'b1;
    #3;
    check("R8", q, 8'h11);
    addr = 3'd6;
    #2;
    check("R8", q, 8'h11);
    @(posedge clk);
    exp_q = model(exp_q, 1'b1, 1'b0, 3'd6, 1'b1);
    @(negedge clk);
    check("R8", q, 8'h51);
    check("R8", q, exp_q);

    // R1: asynchronous system reset in mid-run
    clr_n = 1'b1; wr_en_n = 1'b1;
    #2;
    rst_n = 1'b0;
    #1;
    check("R1", q, 8'h00);
    exp_q = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", q, 8'h00);

    // Seeded random mix of all modes
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 400; i++) begin
      logic c, e, d;
      logic [2:0] a;
      logic [3:0] r;
      r = 4'($urandom());
      c = (r < 4'd12);
      e = ($urandom() % 2) == 0;
      a = 3'($urandom());
      d = 1'($urandom());
      step(c, e, a, d, mode_tag(c, e));
    end

    report();
    $finish;
  end

endmodule